// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the low-order offset bits of a short fixed-length burst. When a new burst address is captured, it takes the low bits of that address as the starting offset. Each clock edge with the active-low advance input asserted moves it one beat further. After the last beat it returns to the starting offset. The offset is meant to be concatenated with the upper address bits, which are registered elsewhere. A beat index is also given so that downstream logic can tell the position inside the burst.

Two beat orderings are supported and chosen by a static mode pin. In interleaved order each offset is the start XOR the beat number. In linear order each offset is the start plus the beat number, wrapping modulo the burst length. Any starting offset is legal in both orders. Internally the block keeps the loaded start and a beat count, and derives the offset from the two with combinational logic.

Top module: `burst_addr_ctr`

## Requirements
- R1: While rst_ni is low, and after it is released with no load, ofs_o and beat_o are both 0.
- R2: On a rising clock edge with load_i high, the start offset is taken from start_ofs_i and the beat count is set to 0. After that edge ofs_o equals start_ofs_i and beat_o equals 0.
- R3: When load_i and advance (adv_ni low) are both active on the same edge, the load wins and beat_o is 0 after that edge.
- R4: On an edge with load_i low and adv_ni low, beat_o steps by one modulo 4 (the default OFS_W=2 gives 4 beats).
- R5: On an edge with load_i low and adv_ni high, ofs_o and beat_o keep their values.
- R6: With mode_i high (interleaved), ofs_o = start XOR beat. For example, start 01 gives 01, 00, 11, 10.
- R7: With mode_i low (linear), ofs_o = (start + beat) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R8: One advance after the fourth beat, beat_o returns to 0 and ofs_o returns to the loaded start. Later advances repeat the same sequence.
- R9: mode_i is static outside reset. A value changed while rst_ni is low applies to every burst after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear; static |
| load_i | input | 1 | Capture start_ofs_i as a new burst start |
| adv_ni | input | 1 | Advance one beat, active low |
| start_ofs_i | input | OFS_W | Low address bits of the new burst |
| ofs_o | output | OFS_W | Current burst offset |
| beat_o | output | OFS_W | Current beat index inside the burst |

## Verification
The hardest states to reach from the ports are a burst that runs past its wrap with holds scattered through it, and a load that lands on the same edge as an advance at a nonzero beat. Directed bursts cover every start value in both orders, with a hold in mid-burst and six advances so that each one crosses the wrap. Random phases then mix loads, holds and advances in each mode, which produces coincident load and advance at arbitrary beats. Mode changes are made only while reset is held, and each mode phase begins after such a change.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned OFS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_ofs_i,
  output logic [OFS_W-1:0] start_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_q_o <= '0;
    else if (load_i) start_q_o <= start_ofs_i;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int unsigned OFS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_ni,
  output logic [OFS_W-1:0] beat_q_o
);
  // load restarts the burst and takes priority over advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q_o <= '0;
    else if (load_i)  beat_q_o <= '0;
    else if (!adv_ni) beat_q_o <= beat_q_o + 1'b1;
  end
endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
  import burst_ctr_pkg::*;
#(
  parameter int unsigned OFS_W = 2
) (
  input  order_e           order_i,
  input  logic [OFS_W-1:0] start_i,
  input  logic [OFS_W-1:0] beat_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] ofs_xor, ofs_add;
  logic [OFS_W:0]   carry;

  assign carry[0] = 1'b0;
  // ripple adder per bit; the top carry is dropped, which gives modulo-2^OFS_W wrap
  for (genvar b = 0; b < OFS_W; b++) begin : g_bit
    assign ofs_xor[b]  = start_i[b] ^ beat_i[b];
    assign ofs_add[b]  = start_i[b] ^ beat_i[b] ^ carry[b];
    assign carry[b+1]  = (start_i[b] & beat_i[b]) | (carry[b] & (start_i[b] ^ beat_i[b]));
  end

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: ofs_o = ofs_xor;
      default:        ofs_o = ofs_add;
    endcase
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_ctr_pkg::*;
#(
  parameter int unsigned OFS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             load_i,
  input  logic             adv_ni,
  input  logic [OFS_W-1:0] start_ofs_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [OFS_W-1:0] beat_o
);
  logic [OFS_W-1:0] start_q, beat_q;
  order_e           order;

  assign order = mode_i ? ORD_INTERLEAVE : ORD_LINEAR;

  burst_start_reg #(.OFS_W(OFS_W)) u_start (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .start_ofs_i(start_ofs_i),
    .start_q_o  (start_q)
  );

  burst_beat_cnt #(.OFS_W(OFS_W)) u_beat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .adv_ni  (adv_ni),
    .beat_q_o(beat_q)
  );

  burst_ofs_map #(.OFS_W(OFS_W)) u_map (
    .order_i(order),
    .start_i(start_q),
    .beat_i (beat_q),
    .ofs_o  (ofs_o)
  );

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int unsigned OFS_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             load_i,
  input logic             adv_ni,
  input logic [OFS_W-1:0] start_ofs_i,
  input logic [OFS_W-1:0] ofs_o,
  input logic [OFS_W-1:0] beat_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_mode_static_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> $stable(mode_i));

  assert_load_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && load_i) |=> (ofs_o == $past(start_ofs_i)) && (beat_o == '0));

  assert_load_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && load_i && !adv_ni) |=> (beat_o == '0));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !load_i && !adv_ni) |=> (beat_o == $past(beat_o) + 1'b1));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !load_i && adv_ni) |=> ($stable(ofs_o) && $stable(beat_o)));

  assert_xor_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && mode_i && !load_i && !adv_ni) |=>
      ((ofs_o ^ $past(ofs_o)) == (beat_o ^ $past(beat_o))));

  assert_lin_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !mode_i && !load_i && !adv_ni) |=> (ofs_o == $past(ofs_o) + 1'b1));

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R1: assert (ofs_o == '0 && beat_o == '0);
  end
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.OFS_W(OFS_W)) u_chk (.*);

// File: tb/burst_addr_ctr_tb.sv
module burst_addr_ctr_tb;
  localparam int CLK_P = 10;
  localparam int W     = 2;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, load = 1'b0, adv_n = 1'b1;
  logic [W-1:0] start = '0, ofs, beat;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] m_start = '0, m_beat = '0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_ctr #(.OFS_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .load_i(load),
    .adv_ni(adv_n), .start_ofs_i(start), .ofs_o(ofs), .beat_o(beat)
  );

  function automatic logic [W-1:0] exp_ofs(logic m, logic [W-1:0] s, logic [W-1:0] b);
    return m ? (s ^ b) : W'(s + b);
  endfunction

  task automatic check(string tag, logic [W-1:0] eo, logic [W-1:0] eb);
    n_vec++;
    if (ofs !== eo || beat !== eb) begin
      n_bad++;
      $display("FAIL %s: ofs=%b beat=%b expected ofs=%b beat=%b", tag, ofs, beat, eo, eb);
    end
  endtask

  task automatic step(logic ld, logic adn, logic [W-1:0] s, string tag_in = "");
    string tag;
    @(negedge clk);
    load = ld; adv_n = adn; start = s;
    @(posedge clk);
    if (ld) begin m_start = s; m_beat = '0; end
    else if (!adn) m_beat = m_beat + 1'b1;
    #(CLK_P/4);
    if (tag_in != "") tag = tag_in;
    else if (ld && !adn) tag = "R3";
    else if (ld) tag = "R2";
    else if (adn) tag = "R5";
    else if (mode) tag = "R6/R4";
    else tag = "R7/R4";
    check(tag, exp_ofs(mode, m_start, m_beat), m_beat);
  endtask

  task automatic reset_with_mode(logic m);
    @(negedge clk);
    rst_n = 1'b0; load = 1'b0; adv_n = 1'b1;
    mode = m;
    m_start = '0; m_beat = '0;
    #(CLK_P/4);
    check("R1", '0, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b17));
    for (int mi = 0; mi < 2; mi++) begin
      reset_with_mode(logic'(mi == 0));
      step(1'b0, 1'b1, '0, "R1");
      step(1'b0, 1'b1, '0, "R9");
      for (int s = 0; s < 4; s++) begin
        step(1'b1, 1'b1, W'(s), "R2");
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b1, '0, "R5");
        step(1'b0, 1'b1, '0, "R5");
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0, "R8");
        step(1'b0, 1'b0, '0, "R8");
        step(1'b0, 1'b0, '0);
      end
      // examples named in R6 and R7
      step(1'b1, 1'b1, mode ? 2'b01 : 2'b10, mode ? "R6" : "R7");
      step(1'b0, 1'b0, '0, mode ? "R6" : "R7");
      step(1'b0, 1'b0, '0, mode ? "R6" : "R7");
      step(1'b0, 1'b0, '0, mode ? "R6" : "R7");
      step(1'b0, 1'b0, '0, "R8");
      // load coinciding with advance at a nonzero beat
      step(1'b0, 1'b0, '0);
      step(1'b1, 1'b0, 2'b11, "R3");
      for (int i = 0; i < 400; i++) begin
        logic ld, adn;
        ld  = ($urandom_range(0, 7) == 0);
        adn = ($urandom_range(0, 2) == 0);
        step(ld, adn, W'($urandom_range(0, 3)));
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule